// File: doc/BRIEF.md
# Eight-Stage Parallel-In Serial-Out Shift Register

This block turns an eight-bit parallel word into a serial bit stream. A level-sensitive load control forces the parallel word into the register as soon as it is raised, without any clock edge. Each stage is a flip-flop with its own direct set and direct clear. Those two lines are derived from the load control and that stage's data bit, so the parallel word overrides both the clock and the serial input for as long as load stays high.

With load low, every rising clock edge moves the contents one stage toward the output end and takes the serial input into the first stage. Only the three stages nearest the output end are visible. Several blocks can be chained by feeding the last tap of one into the serial input of the next. The register is fully static and keeps its contents for as long as the clock is held still.

Top module: `piso_shift8`

## Requirements
- R1: `tap_o[0]`, `tap_o[1]` and `tap_o[2]` show stages 5, 6 and 7. Stage 7 is the last stage, and stages 0 to 4 are not brought out directly.
- R2: While `load_i` is 1, stage i equals `par_i[i]` for every i from 0 to 7, with no clock edge needed.
- R3: While `load_i` is 1, rising edges of `clk_i` and changes of `ser_i` do not alter any stage.
- R4: With `load_i` at 0, a rising edge of `clk_i` copies stage i into stage i+1 for i = 0 to 6 and loads `ser_i` into stage 0.
- R5: With `load_i` at 0 and no rising edge on `clk_i`, the taps hold their value for any length of time, whatever `ser_i` does.
- R6: A change of `par_i` while `load_i` stays 1 shows up in the stages at once.
- R7: After `load_i` falls, the register keeps the last loaded word until the next rising edge of `clk_i`, and that edge shifts the held word.
- R8: After eight consecutive shifting edges with no load in between, the taps hold only serial-input history. `tap_o[2]` holds the bit entered eight edges earlier, and `tap_o[0]` holds the bit entered six edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock, rising edge active |
| load_i | input | 1 | Asynchronous, level-sensitive parallel load, active high |
| ser_i | input | 1 | Serial data taken into stage 0 on each shift |
| par_i | input | 8 | Parallel word; bit i goes to stage i |
| tap_o | output | 3 | Stages 5, 6 and 7 (bit 0 is stage 5) |

## Verification
Words that have a single one bit in an upper position show whether each tap is wired to the right stage. A mixed word shifted several times walks the lower, hidden stages past the taps, which confirms that every bit was loaded and that the shift direction is correct. All-ones and all-zeros loads, each followed by shifts in the opposite value, expose stuck stages and off-by-one shifts. Other sequences check the precedence of load over the clock, the transparent following of the parallel word, the hold after release and with the clock stopped, and the eight-bit serial history that replaces a loaded word.

// File: rtl/piso_pkg.sv
package piso_pkg;

    localparam int unsigned PISO_STAGES = 8;
    localparam int unsigned PISO_TAPS   = 3;

    // Direct control lines for one register stage.
    typedef struct packed {
        logic set;
        logic clr;
    } piso_direct_t;

    // Derive the direct set and clear of one stage from load and its data bit.
    function automatic piso_direct_t piso_direct(input logic load, input logic din);
        piso_direct_t r;
        r.set = load & din;
        r.clr = load & ~din;
        return r;
    endfunction

endpackage

// File: rtl/piso_force_gen.sv
module piso_force_gen #(
    parameter int unsigned STAGES = piso_pkg::PISO_STAGES
) (
    input  logic              load_i,
    input  logic [STAGES-1:0] par_i,
    output logic [STAGES-1:0] set_o,
    output logic [STAGES-1:0] clr_o
);
    import piso_pkg::*;

    for (genvar g = 0; g < STAGES; g++) begin : g_bit
        piso_direct_t ctl;
        always_comb begin
            ctl      = piso_direct(load_i, par_i[g]);
            set_o[g] = ctl.set;
            clr_o[g] = ctl.clr;
        end
    end

endmodule

// File: rtl/piso_cell.sv
module piso_cell (
    input  logic clk_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);

    // Flip-flop with direct clear (dominant) and direct set.
    always_ff @(posedge clk_i or posedge set_i or posedge clr_i) begin
        if (clr_i) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/piso_tap_sel.sv
module piso_tap_sel #(
    parameter int unsigned STAGES = piso_pkg::PISO_STAGES,
    parameter int unsigned TAPS   = piso_pkg::PISO_TAPS
) (
    input  logic [STAGES-1:0] stage_i,
    output logic [TAPS-1:0]   tap_o
);
    localparam int unsigned TAP_BASE = STAGES - TAPS;

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        assign tap_o[g] = stage_i[TAP_BASE + g];
    end

endmodule

// File: rtl/piso_shift8.sv
module piso_shift8 #(
    parameter int unsigned STAGES = piso_pkg::PISO_STAGES,
    parameter int unsigned TAPS   = piso_pkg::PISO_TAPS
) (
    input  logic              clk_i,
    input  logic              load_i,
    input  logic              ser_i,
    input  logic [STAGES-1:0] par_i,
    output logic [TAPS-1:0]   tap_o
);

    logic [STAGES-1:0] set_w;
    logic [STAGES-1:0] clr_w;
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] next_d;

    piso_force_gen #(.STAGES(STAGES)) force_i (
        .load_i (load_i),
        .par_i  (par_i),
        .set_o  (set_w),
        .clr_o  (clr_w)
    );

    // Serial path: stage 0 takes ser_i, stage i takes stage i-1.
    assign next_d = {stage_q[STAGES-2:0], ser_i};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        piso_cell cell_i (
            .clk_i (clk_i),
            .set_i (set_w[g]),
            .clr_i (clr_w[g]),
            .d_i   (next_d[g]),
            .q_o   (stage_q[g])
        );
    end

    piso_tap_sel #(.STAGES(STAGES), .TAPS(TAPS)) taps_i (
        .stage_i (stage_q),
        .tap_o   (tap_o)
    );

endmodule

// File: rtl/piso_shift8_chk.sv
module piso_shift8_chk #(
    parameter int unsigned STAGES = 8,
    parameter int unsigned TAPS   = 3
) (
    input logic              clk_i,
    input logic              load_i,
    input logic              ser_i,
    input logic [STAGES-1:0] par_i,
    input logic [STAGES-1:0] stage_i,
    input logic [TAPS-1:0]   tap_o
);

    int unsigned       rise_cnt    = 0;
    int unsigned       rise_at_clk = 0;
    int unsigned       clk_cnt     = 0;
    int unsigned       fall_clk    = 0;
    int unsigned       run         = 0;
    logic              primed      = 1'b0;
    logic              shift_ok    = 1'b0;
    logic [STAGES-1:0] snap        = '0;
    logic [STAGES-1:0] fall_word   = '0;
    logic [STAGES-1:0] hist        = '0;

    always @(posedge load_i) rise_cnt <= rise_cnt + 1;

    always @(negedge load_i) begin
        primed    <= 1'b1;
        fall_word <= stage_i;
        fall_clk  <= clk_cnt;
    end

    always @(posedge clk_i) begin
        clk_cnt     <= clk_cnt + 1;
        rise_at_clk <= rise_cnt;
        shift_ok    <= primed && !load_i;
        snap        <= {stage_i[STAGES-2:0], ser_i};
        if (!load_i) hist <= {hist[STAGES-2:0], ser_i};
        if (load_i) begin
            run <= 0;
        end else if (rise_cnt != rise_at_clk) begin
            run <= 1;
        end else if (run < STAGES) begin
            run <= run + 1;
        end
    end

    always @(negedge clk_i) begin
        if (primed && load_i) begin
            p_load_follows_r2: assert (stage_i == par_i)
                else $error("p_load_follows_r2 stage=%b par=%b", stage_i, par_i);
        end
        if (shift_ok && !load_i && rise_cnt == rise_at_clk) begin
            p_shift_step_r4: assert (stage_i == snap)
                else $error("p_shift_step_r4 stage=%b exp=%b", stage_i, snap);
        end
        if (primed && !load_i && clk_cnt == fall_clk + 1 && rise_cnt == rise_at_clk) begin
            p_release_hold_r7: assert (stage_i == {fall_word[STAGES-2:0], snap[0]})
                else $error("p_release_hold_r7 stage=%b word=%b", stage_i, fall_word);
        end
        if (!load_i && run == STAGES && rise_cnt == rise_at_clk) begin
            p_serial_hist_r8: assert (tap_o == hist[STAGES-1 -: TAPS])
                else $error("p_serial_hist_r8 tap=%b hist=%b", tap_o, hist);
        end
    end

endmodule

bind piso_shift8 piso_shift8_chk #(.STAGES(STAGES), .TAPS(TAPS)) chk_i (
    .clk_i   (clk_i),
    .load_i  (load_i),
    .ser_i   (ser_i),
    .par_i   (par_i),
    .stage_i (stage_q),
    .tap_o   (tap_o)
);

// File: tb/piso_shift8_tb_top.sv
`timescale 1ns/1ps
module piso_shift8_tb_top;

    logic       clk_raw = 1'b0;
    logic       clk_en  = 1'b0;
    logic       clk;
    logic       load    = 1'b0;
    logic       ser     = 1'b0;
    logic [7:0] par     = 8'h00;
    logic [2:0] tap;
    logic [7:0] mdl     = 8'h00;
    int         n_chk   = 0;
    int         n_err   = 0;

    always #4 clk_raw = ~clk_raw;   // 8 ns period, 125 MHz
    assign clk = clk_raw & clk_en;

    piso_shift8 dut_i (
        .clk_i  (clk),
        .load_i (load),
        .ser_i  (ser),
        .par_i  (par),
        .tap_o  (tap)
    );

    // Vector: {op(1: shift, 0: load), data[7:0], ser, expected taps[2:0]}
    localparam int NVEC = 10;
    localparam logic [12:0] VEC [0:NVEC-1] = '{
        {1'b0, 8'hA6, 1'b0, 3'b101},   // R1 mixed word
        {1'b1, 8'h00, 1'b1, 3'b010},   // R4
        {1'b1, 8'h00, 1'b0, 3'b100},   // R4
        {1'b1, 8'h00, 1'b1, 3'b001},   // R4
        {1'b0, 8'h20, 1'b0, 3'b001},   // R1 stage 5
        {1'b0, 8'h40, 1'b0, 3'b010},   // R1 stage 6
        {1'b0, 8'h80, 1'b0, 3'b100},   // R1 stage 7
        {1'b0, 8'hFF, 1'b0, 3'b111},   // R2 all ones
        {1'b1, 8'h00, 1'b0, 3'b111},   // R4 shift zero into ones
        {1'b0, 8'h00, 1'b1, 3'b000}    // R2 all zeros
    };

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if (tap !== exp) begin
            n_err++;
            $display("FAIL %s: tap_o=%b expected %b", req, tap, exp);
        end
    endtask

    task automatic do_load(input logic [7:0] w);
        @(negedge clk_raw);
        #1 par = w; load = 1'b1; mdl = w;
        #2 load = 1'b0;
        #1;
    endtask

    task automatic do_shift(input logic s);
        @(negedge clk_raw);
        #1 ser = s; clk_en = 1'b1;
        @(negedge clk_raw);
        #1 clk_en = 1'b0;
        mdl = {mdl[6:0], s};
    endtask

    initial begin
        #(8 * 200000);
        n_err++; n_chk++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][12]) do_shift(VEC[i][3]);
            else            do_load(VEC[i][11:4]);
            check(VEC[i][12] ? "R4 table shift" : "R1 table load", VEC[i][2:0]);
        end

        // R2/R4: hidden stages 0-4 walk into the taps
        do_load(8'b0001_1010);
        for (int k = 0; k < 5; k++) begin
            do_shift(1'b0);
            check("R2 hidden stage via shift", mdl[7:5]);
        end

        // R3: load held high across clock edges, serial toggling
        @(negedge clk_raw);
        #1 par = 8'b0101_0000; load = 1'b1; mdl = par; clk_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_raw);
            #1 ser = ~ser;
            check("R3 clock ignored under load", 3'b010);
        end
        // R6: parallel word changes while load stays high
        #1 par = 8'b1110_0000;
        #1 check("R6 follows par (set)", 3'b111);
        #1 par = 8'b0000_0000;
        #1 check("R6 follows par (clear)", 3'b000);
        #1 par = 8'b1010_0000; mdl = par;
        @(negedge clk_raw);
        #1 clk_en = 1'b0;
        #1 load = 1'b0;
        // R7: word held after release until a clock edge
        repeat (5) @(negedge clk_raw);
        #1 check("R7 hold after release", 3'b101);
        do_shift(1'b1);
        check("R7 first shift of held word", 3'b010);

        // R5: clock stopped, serial input wiggles
        for (int k = 0; k < 20; k++) begin
            @(negedge clk_raw);
            #1 ser = k[0];
        end
        check("R5 static hold", 3'b010);

        // R8: eight shifts replace loaded ones with serial history
        do_load(8'hFF);
        do_shift(1'b1); do_shift(1'b0); do_shift(1'b1); do_shift(1'b1);
        do_shift(1'b0); do_shift(1'b0); do_shift(1'b1); do_shift(1'b0);
        check("R8 serial history", 3'b101);
        check("R8 stage7 is first bit", {1'b1, mdl[6:5]});
        for (int k = 0; k < 8; k++) do_shift(1'b1);
        check("R8 all ones shifted", 3'b111);
        for (int k = 0; k < 8; k++) do_shift(1'b0);
        check("R8 all zeros shifted", 3'b000);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule